// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the address phase of an I2C transfer is addressed to this device. It sits behind a byte shifter: each time a whole byte has been received, the shifter presents it together with a one-cycle valid strobe. A one-cycle START pulse marks the beginning of every transfer. The matcher compares the first address byte, and in 10-bit mode also the second, against a bank of programmable slave address entries. It then raises a registered match flag with the index of the entry that matched, or a general-call flag.

Two mode inputs are sampled when each byte arrives. The format input bypasses recognition entirely. In that free data format the transfer may always proceed, and no flag is raised. The width input selects between 7-bit and 10-bit addressing. Each entry is 10 bits wide. In 7-bit mode only its upper 7 bits take part in the comparison. In 10-bit mode all 10 bits take part, spread over two address bytes. Once the address phase is decided, further bytes leave the flags alone until the next START.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `match_o`, `gcall_o` and `match_idx_o` are 0.
- R2: In 7-bit mode (`ten_bit_i`=0, `free_fmt_i`=0), a first byte whose bits [7:1] equal bits [9:3] of an entry sets `match_o` one cycle after the strobe. Bit 0 of the byte (read/write) plays no part in the comparison.
- R3: When several entries match, `match_idx_o` reports the lowest-numbered one.
- R4: Outside free format, a first byte of 0x00 sets `gcall_o` and never `match_o`. This holds even when an entry would match that byte.
- R5: In 10-bit mode, a match needs two bytes. The first byte must be {11110, entry[9:8], r/w}. The second byte must equal entry[7:0]. `match_o` rises one cycle after the second byte.
- R6: In 10-bit mode, if either byte fails to match, no flag is raised. If the first byte fails, the next byte is not treated as a second address byte.
- R7: In free format (`free_fmt_i`=1), received bytes raise neither flag.
- R8: `proceed_o` is high exactly when `free_fmt_i`, `match_o` or `gcall_o` is high.
- R9: A START pulse clears both flags, the index and any pending 10-bit sequence on the next edge. A byte strobed in the same cycle as START is ignored.
- R10: Once the address phase is decided, further bytes leave the flags and the index unchanged until the next START.
- R11: In 10-bit mode, `match_o` stays low after the first byte alone, even when that byte would match in 7-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse at a START condition |
| byte_valid_i | input | 1 | Received byte is valid this cycle |
| byte_i | input | 8 | Received byte |
| free_fmt_i | input | 1 | 1: free data format, no address recognition |
| ten_bit_i | input | 1 | 1: 10-bit addressing, 0: 7-bit addressing |
| sar_i | input | NUM_SAR*10 | Slave address entries; entry k at bits [10k+9:10k] |
| match_o | output | 1 | Address matched an entry |
| match_idx_o | output | IDX_W | Index of the matching entry |
| gcall_o | output | 1 | General call received |
| proceed_o | output | 1 | Transfer processing may proceed |

## Verification
The hardest situation to reach is a 10-bit second byte that arrives while several entries are still pending from the first byte. Only the stored candidate set, and not a fresh comparison, may then decide the index. The bench reaches this with entry sets that share their upper bits, and pairs each prefix byte with a full sweep of second bytes. A START that lands between the two 10-bit bytes is driven directly. The bench then confirms that the following byte is taken as a new first byte.

// File: rtl/i2c_am_pkg.sv
// Package: shared constants and the sequencing state type of the address matcher.
package i2c_am_pkg;
    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;
    localparam logic [BYTE_W-1:0] GCALL_BYTE = 8'h00;

    typedef enum logic [1:0] {
        AM_FIRST  = 2'd0,
        AM_SECOND = 2'd1,
        AM_DONE   = 2'd2
    } am_state_e;
endpackage

// File: rtl/am_cmp.sv
// Module: am_cmp
// Compares one received byte with every slave address entry in parallel.
// The 7-bit hit, the 10-bit first-byte hit and the 10-bit second-byte hit are
// produced side by side. Assumes entries are ADDR_W bits, packed lowest index first.
module am_cmp
    import i2c_am_pkg::*;
#(
    parameter int NUM_SAR = 3
) (
    input  logic [NUM_SAR*ADDR_W-1:0] sar_i,
    input  logic [BYTE_W-1:0]         byte_i,
    output logic [NUM_SAR-1:0]        hit7_o,
    output logic [NUM_SAR-1:0]        hit10hi_o,
    output logic [NUM_SAR-1:0]        hit10lo_o
);
    for (genvar g = 0; g < NUM_SAR; g++) begin : g_entry
        logic [ADDR_W-1:0] entry;
        // Slice out entry g.
        assign entry        = sar_i[g*ADDR_W +: ADDR_W];
        // 7-bit: byte bits 7..1 against the entry's upper 7 bits.
        assign hit7_o[g]    = (byte_i[7:1] == entry[9:3]);
        // 10-bit first byte: prefix and the entry's two top bits.
        assign hit10hi_o[g] = (byte_i[7:3] == TEN_PREFIX) && (byte_i[2:1] == entry[9:8]);
        // 10-bit second byte: the entry's low eight bits.
        assign hit10lo_o[g] = (byte_i == entry[7:0]);
    end
endmodule

// File: rtl/am_prio.sv
// Module: am_prio
// Lowest-index-first priority encoder over a candidate mask.
// Assumes IDX_W can hold NUM_SAR-1.
module am_prio #(
    parameter int NUM_SAR = 3,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_SAR-1:0] mask_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        any_o = |mask_i;
        idx_o = '0;
        for (int i = NUM_SAR - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/am_seq.sv
// Module: am_seq
// Address-phase sequencer. It tracks first byte, pending second byte and decided,
// and holds the match, index and general-call flags. Assumes start_i and
// byte_valid_i are single-cycle strobes. START takes priority over a byte.
module am_seq
    import i2c_am_pkg::*;
#(
    parameter int NUM_SAR = 3,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               byte_valid_i,
    input  logic               free_fmt_i,
    input  logic               ten_bit_i,
    input  logic               gcall_byte_i,
    input  logic [NUM_SAR-1:0] hit7_i,
    input  logic [NUM_SAR-1:0] hit10hi_i,
    input  logic [NUM_SAR-1:0] hit10lo_i,
    output logic [NUM_SAR-1:0] cand_o,
    input  logic               cand_any_i,
    input  logic [IDX_W-1:0]   cand_idx_i,
    output logic               match_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               gcall_o
);
    am_state_e          state_q;
    logic [NUM_SAR-1:0] pend_q;

    // Pick the candidate set: stored prefix hits when waiting, else 7-bit hits.
    always_comb begin
        cand_o = (state_q == AM_SECOND) ? (pend_q & hit10lo_i) : hit7_i;
    end

    // Advance the address phase and update the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AM_FIRST;
            pend_q  <= '0;
            match_o <= 1'b0;
            idx_o   <= '0;
            gcall_o <= 1'b0;
        end else if (start_i) begin
            state_q <= AM_FIRST;
            pend_q  <= '0;
            match_o <= 1'b0;
            idx_o   <= '0;
            gcall_o <= 1'b0;
        end else if (byte_valid_i && !free_fmt_i) begin
            case (state_q)
                AM_FIRST: begin
                    state_q <= AM_DONE;
                    if (gcall_byte_i) begin
                        gcall_o <= 1'b1;
                    end else if (!ten_bit_i) begin
                        if (cand_any_i) begin
                            match_o <= 1'b1;
                            idx_o   <= cand_idx_i;
                        end
                    end else if (|hit10hi_i) begin
                        state_q <= AM_SECOND;
                        pend_q  <= hit10hi_i;
                    end
                end
                AM_SECOND: begin
                    state_q <= AM_DONE;
                    pend_q  <= '0;
                    if (cand_any_i) begin
                        match_o <= 1'b1;
                        idx_o   <= cand_idx_i;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
// Module: i2c_addr_match (top)
// Matches received I2C address bytes against NUM_SAR slave address entries.
// It supports 7-bit and 10-bit addressing, general call and a free data format.
// Assumes bytes arrive already assembled with a one-cycle valid strobe.
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int NUM_SAR = 3,
    parameter int IDX_W   = (NUM_SAR > 1) ? $clog2(NUM_SAR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      byte_valid_i,
    input  logic [BYTE_W-1:0]         byte_i,
    input  logic                      free_fmt_i,
    input  logic                      ten_bit_i,
    input  logic [NUM_SAR*ADDR_W-1:0] sar_i,
    output logic                      match_o,
    output logic [IDX_W-1:0]          match_idx_o,
    output logic                      gcall_o,
    output logic                      proceed_o
);
    logic [NUM_SAR-1:0] hit7, hit10hi, hit10lo, cand;
    logic               cand_any;
    logic [IDX_W-1:0]   cand_idx;
    logic               gcall_byte;

    // Detect the general-call byte value.
    assign gcall_byte = (byte_i == GCALL_BYTE);

    am_cmp #(.NUM_SAR(NUM_SAR)) u_cmp (
        .sar_i     (sar_i),
        .byte_i    (byte_i),
        .hit7_o    (hit7),
        .hit10hi_o (hit10hi),
        .hit10lo_o (hit10lo)
    );

    am_prio #(.NUM_SAR(NUM_SAR), .IDX_W(IDX_W)) u_prio (
        .mask_i (cand),
        .any_o  (cand_any),
        .idx_o  (cand_idx)
    );

    am_seq #(.NUM_SAR(NUM_SAR), .IDX_W(IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .free_fmt_i   (free_fmt_i),
        .ten_bit_i    (ten_bit_i),
        .gcall_byte_i (gcall_byte),
        .hit7_i       (hit7),
        .hit10hi_i    (hit10hi),
        .hit10lo_i    (hit10lo),
        .cand_o       (cand),
        .cand_any_i   (cand_any),
        .cand_idx_i   (cand_idx),
        .match_o      (match_o),
        .idx_o        (match_idx_o),
        .gcall_o      (gcall_o)
    );

    // Transfer may proceed in free format or once the address phase succeeded.
    assign proceed_o = free_fmt_i | match_o | gcall_o;
endmodule

// File: rtl/i2c_addr_match_chk.sv
// Module: i2c_addr_match_chk
// Temporal checks on the matcher's ports. Attached to every instance by bind.
module i2c_addr_match_chk #(
    parameter int NUM_SAR = 3,
    parameter int IDX_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             byte_valid_i,
    input logic             free_fmt_i,
    input logic             match_o,
    input logic [IDX_W-1:0] match_idx_o,
    input logic             gcall_o
);
    // R4: general call and address match never together.
    assert_excl_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_o && gcall_o));
    // R9: START clears the flags on the next edge.
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!match_o && !gcall_o));
    // R2: a flag can rise only one cycle after a byte strobe.
    assert_rise_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(match_o) || $rose(gcall_o)) |-> $past(byte_valid_i));
    // R7: no flag rises from a byte taken in free format.
    assert_free_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(match_o) || $rose(gcall_o)) |-> !$past(free_fmt_i));
    // R10: a decided match holds with a stable index until START.
    assert_match_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !start_i) |=> (match_o && $stable(match_idx_o)));
    // R3: a reported index names an existing entry.
    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (int'(match_idx_o) < NUM_SAR));
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.NUM_SAR(NUM_SAR), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .free_fmt_i   (free_fmt_i),
    .match_o      (match_o),
    .match_idx_o  (match_idx_o),
    .gcall_o      (gcall_o)
);

// File: tb/i2c_addr_match_bench.sv
// Bench: sweeps every first byte and every second byte over two entry sets and
// all mode combinations. Expected flags come from an arithmetic model.
module i2c_addr_match_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSAR = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       free_fmt_i = 1'b0;
    logic       ten_bit_i = 1'b0;
    logic [29:0] sar_i = '0;
    logic       match_o, gcall_o, proceed_o;
    logic [1:0] match_idx_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_match u_i2c_addr_match (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .free_fmt_i(free_fmt_i), .ten_bit_i(ten_bit_i),
        .sar_i(sar_i), .match_o(match_o), .match_idx_o(match_idx_o),
        .gcall_o(gcall_o), .proceed_o(proceed_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] ent(input int k);
        return sar_i[k*10 +: 10];
    endfunction

    // Model: expected flags after nb address bytes; returns the candidate count in ncand.
    task automatic model(input bit fr, input bit tb, input logic [7:0] b0, input logic [7:0] b1,
                         input int nb, output bit m, output int idx, output bit g, output int ncand);
        m = 0; idx = 0; g = 0; ncand = 0;
        if (fr) return;
        if (b0 == 8'h00) begin g = 1; return; end
        for (int k = NSAR - 1; k >= 0; k--) begin
            logic [9:0] e;
            bit hit;
            e = ent(k);
            if (!tb) hit = (int'(b0 >> 1) == int'(e >> 3));
            else hit = (nb == 2) && (int'(b0 >> 3) == 30) && (int'((b0 >> 1) & 3) == int'(e >> 8))
                       && (int'(b1) == int'(e & 10'hFF));
            if (hit) begin m = 1; idx = k; ncand++; end
        end
    endtask

    task automatic cmp_out(input string tag, input bit m, input int idx, input bit g, input bit fr);
        chk(match_o == m, tag, match_o, m);
        chk(gcall_o == g, tag, gcall_o, g);
        if (m) chk(int'(match_idx_o) == idx, tag, match_idx_o, idx);
        chk(proceed_o == (fr | m | g), "R8 proceed", proceed_o, fr | m | g);
    endtask

    // One transfer: START, first byte, second byte, then an extra byte.
    task automatic txn(input bit fr, input bit tb, input logic [7:0] b0, input logic [7:0] b1);
        bit m, g; int idx, nc;
        string tag;
        @(negedge clk);
        free_fmt_i = fr; ten_bit_i = tb; start_i = 1; byte_valid_i = 0;
        @(negedge clk);
        start_i = 0; byte_valid_i = 1; byte_i = b0;
        @(negedge clk);
        model(fr, tb, b0, b1, 1, m, idx, g, nc);
        tag = fr ? "R7 free" : (g ? "R4 gcall" : (tb ? "R11 ten first" : (nc > 1 ? "R3 prio7" : "R2 seven")));
        cmp_out(tag, m, idx, g, fr);
        byte_i = b1;
        @(negedge clk);
        byte_valid_i = 0;
        model(fr, tb, b0, b1, tb ? 2 : 1, m, idx, g, nc);
        tag = fr ? "R7 free" : (g ? "R4 gcall" : (!tb ? "R10 seven second" :
              (nc > 1 ? "R3 prio10" : (m ? "R5 ten" : "R6 ten miss"))));
        cmp_out(tag, m, idx, g, fr);
        byte_valid_i = 1; byte_i = {ent(0)[9:3], 1'b0};
        @(negedge clk);
        byte_valid_i = 0;
        cmp_out("R10 extra", m, idx, g, fr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(match_o == 0 && gcall_o == 0 && match_idx_o == 0, "R1 reset", {match_o, gcall_o, match_idx_o}, 0);
        rst_n = 1;
        for (int s = 0; s < 2; s++) begin
            // Set 0: entries 0/1 share upper bits. Set 1: entry 0 upper 7 bits zero, entries 1 and 2 equal.
            if (s == 0) sar_i = {10'b01_0011_0001, 10'b10_1100_1111, 10'b10_1100_1010};
            else        sar_i = {10'h2F3, 10'h2F3, 10'h005};
            for (int fr = 0; fr < 2; fr++)
                for (int tb = 0; tb < 2; tb++)
                    for (int b = 0; b < 256; b++)
                        for (int j = 0; j < 4; j++)
                            txn(fr[0], tb[0], 8'(b), (j == 3) ? 8'h00 : ent(j)[7:0]);
            for (int k = 0; k < NSAR; k++)
                for (int b = 0; b < 256; b++)
                    txn(1'b0, 1'b1, {5'b11110, ent(k)[9:8], b[0]}, 8'(b));
        end
        // R9: START in the same cycle as a matching byte wins; the byte is ignored.
        sar_i = {10'b01_0011_0001, 10'b10_1100_1111, 10'b10_1100_1010};
        txn(1'b0, 1'b0, {ent(1)[9:3], 1'b1}, 8'h00);
        @(negedge clk);
        start_i = 1; byte_valid_i = 1; byte_i = {ent(2)[9:3], 1'b0};
        @(negedge clk);
        start_i = 0; byte_valid_i = 0;
        chk(match_o == 0 && gcall_o == 0, "R9 start clears", {match_o, gcall_o}, 0);
        byte_valid_i = 1; byte_i = {ent(2)[9:3], 1'b0};
        @(negedge clk);
        byte_valid_i = 0;
        chk(match_o == 1 && match_idx_o == 2, "R9 byte after start is first", {match_o, match_idx_o}, 6);
        // R9: START between the two 10-bit bytes drops the pending sequence.
        ten_bit_i = 1;
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0; byte_valid_i = 1; byte_i = {5'b11110, ent(0)[9:8], 1'b0};
        @(negedge clk); byte_valid_i = 0; start_i = 1;
        @(negedge clk); start_i = 0; byte_valid_i = 1; byte_i = ent(0)[7:0];
        @(negedge clk); byte_valid_i = 0;
        chk(match_o == 0, "R9 pending cleared", match_o, 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule